// File: doc/BRIEF.md
# Periodic Tick and Watchdog Timer

This block divides the system clock (nominally 32768 Hz) through a single shared counter chain. One bit of that chain, picked by a 3-bit rate code, gives a periodic time-base tick of 1 to 128 Hz. A further divide-by-four stage, fed by those ticks, gives a watchdog time-out at one quarter of the tick rate, so the time-out interval runs from 4 s down to 1/32 s.

The controls come in as single-cycle strobes already decoded from a serial command interface: switch the tick output to the interrupt on or off, switch the watchdog flag on or off, switch the interrupt line on or off, clear the shared chain, clear the watchdog stage, and load a new rate code. The interrupt output is active low and is meant to drive an open-drain pad. When the watchdog flag is on, a time-out holds the line low until software clears or masks it. When the tick output is on, each tick pulls the line low for half a tick period. The raw tick and raw time-out pulses are brought out as well, and they do not depend on any enable.

Top module: `tbw_timebase_wdt`

## Requirements
- R1: After synchronous reset: all three enables are off, the rate code is RATE_RST (default 7), the shared counter is zero, `irq_n_o` is 1, and `tick_o` and `tout_o` are 0. With the default rate, the first tick comes 2^(BASE_W-1) clocks after reset is released.
- R2: With rate code c, `tick_o` is a one-cycle pulse that repeats every 2^(BASE_W+7-c) clocks, whatever the enables are. With BASE_W = 8, code 7 divides the clock by 256 (128 Hz at 32768 Hz) and code 0 divides it by 32768 (1 Hz).
- R3: `tick_o` rises in the clock right after the edge at which bit BASE_W+6-c of the shared counter goes from 0 to 1. The shared counter counts clock edges since the last timer clear or reset.
- R4: A timer-clear strobe sets the shared counter to zero, and no tick comes out of that edge. The next tick follows half a tick period later. The watchdog stage is left as it is.
- R5: `tout_o` pulses together with every fourth tick, counted from the last watchdog clear or reset. A watchdog-clear strobe resets this count, and no time-out comes out of that edge.
- R6: The tick, watchdog and interrupt enables are set and cleared each by their own strobe pair and do not affect each other. If the on and off strobes of the same enable arrive together, off wins. While the interrupt enable is off, `irq_n_o` stays 1.
- R7: With the watchdog enable on, a time-out sets a latched flag. With the interrupt enable on, `irq_n_o` is 0 from one cycle after the time-out pulse until a watchdog-clear, watchdog-off or interrupt-off strobe. Each of these strobes also clears the flag.
- R8: With both the tick enable and the interrupt enable on, `irq_n_o` goes to 0 one cycle after each tick and stays there for exactly half the tick period. It is then 1 for the other half.
- R9: A new rate code loaded in the middle of a count takes effect at the next 0-to-1 transition of the newly selected counter bit. The counter is not reset, and there is no extra tick at either the old or the new rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_on_i | input | 1 | Strobe: turn tick output to the interrupt on |
| tmr_off_i | input | 1 | Strobe: turn tick output to the interrupt off |
| tmr_clr_i | input | 1 | Strobe: clear shared divider chain |
| wdt_on_i | input | 1 | Strobe: turn watchdog flag on |
| wdt_off_i | input | 1 | Strobe: turn watchdog flag off and clear it |
| wdt_clr_i | input | 1 | Strobe: clear watchdog stage and flag |
| irq_on_i | input | 1 | Strobe: enable interrupt line |
| irq_off_i | input | 1 | Strobe: mask interrupt line and clear watchdog flag |
| rate_we_i | input | 1 | Strobe: load rate code |
| rate_i | input | SEL_W | Rate code; tick rate 2^code Hz at 32768 Hz |
| irq_n_o | output | 1 | Interrupt, active low, registered |
| tick_o | output | 1 | Raw time-base tick pulse |
| tout_o | output | 1 | Raw watchdog time-out pulse |

## Verification
The tick period is measured at the fastest, a middle and the slowest rate code, which shows whether the tap index is counted from the right end of the chain. Rate codes are also loaded mid-count, in both the slower-to-faster and faster-to-slower directions, and the first tick is compared with a counter model kept in the bench. This separates a switch at the next transition of the new tap from a spurious edge or a silent reset. The interrupt line is tested under each way a latched watchdog flag can be released, with the interrupt masked, and under tick-driven low phases whose width is measured. This tells apart a level that is latched, a level that follows the tap, and one that is merely pulsed.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  // Enable state held by the control block
  typedef struct packed {
    logic tmr_en;
    logic wdt_en;
    logic irq_en;
  } tbw_en_t;

  // Number of counter bits in the shared chain for a prescaler and rate field
  function automatic int chain_width(input int base_w, input int sel_w);
    return base_w + (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl #(
  parameter int SEL_W    = 3,
  parameter int RATE_RST = (1 << SEL_W) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tmr_on_i,
  input  logic                tmr_off_i,
  input  logic                wdt_on_i,
  input  logic                wdt_off_i,
  input  logic                irq_on_i,
  input  logic                irq_off_i,
  input  logic                rate_we_i,
  input  logic [SEL_W-1:0]    rate_i,
  output tbw_pkg::tbw_en_t    en_o,
  output logic [SEL_W-1:0]    rate_o
);
  tbw_pkg::tbw_en_t en_q;
  logic [SEL_W-1:0] rate_q;

  // off strobe has priority over on strobe for each enable
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      rate_q <= SEL_W'(RATE_RST);
    end else begin
      if (tmr_off_i)     en_q.tmr_en <= 1'b0;
      else if (tmr_on_i) en_q.tmr_en <= 1'b1;
      if (wdt_off_i)     en_q.wdt_en <= 1'b0;
      else if (wdt_on_i) en_q.wdt_en <= 1'b1;
      if (irq_off_i)     en_q.irq_en <= 1'b0;
      else if (irq_on_i) en_q.irq_en <= 1'b1;
      if (rate_we_i)     rate_q      <= rate_i;
    end
  end

  assign en_o   = en_q;
  assign rate_o = rate_q;

  AST_TMR_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
    tmr_off_i |=> !en_o.tmr_en); // R6
  AST_IRQ_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
    irq_off_i |=> !en_o.irq_en); // R6
  AST_WDT_ON_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en_o.wdt_en && !wdt_off_i) |=> en_o.wdt_en); // R6
endmodule

// File: rtl/tbw_divider.sv
module tbw_divider #(
  parameter int BASE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_evt_o,
  output logic             tick_o,
  output logic             tap_o
);
  localparam int NCODE = 1 << SEL_W;
  localparam int DIV_W = tbw_pkg::chain_width(BASE_W, SEL_W);

  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  logic [NCODE-1:0] tap_cur, tap_nxt;
  logic             tick_q, tap_q;

  assign cnt_nxt = clr_i ? '0 : cnt_q + 1'b1;

  // rate code g selects counter bit DIV_W-1-g: higher code, faster tick
  for (genvar g = 0; g < NCODE; g++) begin : g_tap
    assign tap_cur[g] = cnt_q[DIV_W-1-g];
    assign tap_nxt[g] = cnt_nxt[DIV_W-1-g];
  end

  // tick on the rising transition of the currently selected tap
  assign tick_evt_o = !tap_cur[sel_i] && tap_nxt[sel_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      tap_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      tick_q <= tick_evt_o;
      tap_q  <= tap_nxt[sel_i];
    end
  end

  assign tick_o = tick_q;
  assign tap_o  = tap_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R2
  AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !tick_o); // R4
  AST_CLR_TAP_LOW: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !tap_o); // R4
endmodule

// File: rtl/tbw_wdt.sv
module tbw_wdt #(
  parameter int WDT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_evt_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic release_i,
  output logic tout_o,
  output logic flag_o
);
  localparam logic [WDT_W-1:0] LAST = '1;

  logic [WDT_W-1:0] stage_q;
  logic             tout_evt, tout_q, flag_q;

  assign tout_evt = tick_evt_i && (stage_q == LAST) && !clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      tout_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (clr_i)           stage_q <= '0;
      else if (tick_evt_i) stage_q <= stage_q + 1'b1;
      tout_q <= tout_evt;
      if (release_i)               flag_q <= 1'b0;
      else if (en_i && tout_evt)   flag_q <= 1'b1;
    end
  end

  assign tout_o = tout_q;
  assign flag_o = flag_q;

  AST_WCLR_NO_TOUT: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !tout_o); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !release_i) |=> flag_o); // R7
  AST_FLAG_RELEASE: assert property (@(posedge clk) disable iff (rst)
    release_i |=> !flag_o); // R7
endmodule

// File: rtl/tbw_timebase_wdt.sv
module tbw_timebase_wdt #(
  parameter int BASE_W   = 8,
  parameter int SEL_W    = 3,
  parameter int WDT_W    = 2,
  parameter int RATE_RST = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_on_i,
  input  logic             tmr_off_i,
  input  logic             tmr_clr_i,
  input  logic             wdt_on_i,
  input  logic             wdt_off_i,
  input  logic             wdt_clr_i,
  input  logic             irq_on_i,
  input  logic             irq_off_i,
  input  logic             rate_we_i,
  input  logic [SEL_W-1:0] rate_i,
  output logic             irq_n_o,
  output logic             tick_o,
  output logic             tout_o
);
  tbw_pkg::tbw_en_t en;
  logic [SEL_W-1:0] rate;
  logic             tick_evt, tap, flag, irq_n_q;

  tbw_ctrl #(.SEL_W(SEL_W), .RATE_RST(RATE_RST)) u_ctrl (
    .clk(clk), .rst(rst),
    .tmr_on_i(tmr_on_i), .tmr_off_i(tmr_off_i),
    .wdt_on_i(wdt_on_i), .wdt_off_i(wdt_off_i),
    .irq_on_i(irq_on_i), .irq_off_i(irq_off_i),
    .rate_we_i(rate_we_i), .rate_i(rate_i),
    .en_o(en), .rate_o(rate)
  );

  tbw_divider #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .clr_i(tmr_clr_i), .sel_i(rate),
    .tick_evt_o(tick_evt), .tick_o(tick_o), .tap_o(tap)
  );

  tbw_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst(rst), .tick_evt_i(tick_evt), .clr_i(wdt_clr_i),
    .en_i(en.wdt_en), .release_i(wdt_clr_i | wdt_off_i | irq_off_i),
    .tout_o(tout_o), .flag_o(flag)
  );

  // registered active-low interrupt level
  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= !(en.irq_en && (flag || (en.tmr_en && tap)));
  end

  assign irq_n_o = irq_n_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !en.irq_en |=> irq_n_o); // R6
  AST_TOUT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    tout_o |-> tick_o); // R5
  AST_FLAG_PULLS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (en.irq_en && flag) |=> !irq_n_o); // R7
  AST_TICK_PULLS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (en.irq_en && en.tmr_en && tick_o) |=> !irq_n_o); // R8
endmodule

// File: tb/tb_tbw_timebase_wdt.sv
module tb_tbw_timebase_wdt;
  localparam int BASE_W = 3;
  localparam int SEL_W  = 3;
  localparam int DIV_W  = BASE_W + (1 << SEL_W) - 1;

  localparam int C_TON = 1, C_TOFF = 2, C_TCLR = 4, C_WON = 8, C_WOFF = 16,
                 C_WCLR = 32, C_ION = 64, C_IOFF = 128, C_RATE = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0] cmd = '0;
  logic [SEL_W-1:0] rate_v = '0;
  logic irq_n, tick, tout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tbw_timebase_wdt #(.BASE_W(BASE_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst(rst),
    .tmr_on_i(cmd[0]), .tmr_off_i(cmd[1]), .tmr_clr_i(cmd[2]),
    .wdt_on_i(cmd[3]), .wdt_off_i(cmd[4]), .wdt_clr_i(cmd[5]),
    .irq_on_i(cmd[6]), .irq_off_i(cmd[7]), .rate_we_i(cmd[8]),
    .rate_i(rate_v), .irq_n_o(irq_n), .tick_o(tick), .tout_o(tout)
  );

  function automatic int period(input int code);
    return 1 << (DIV_W - code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send(input int mask);
    cmd = mask[8:0];
    @(posedge clk); @(negedge clk);
    cmd = '0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin step(); n++; end while (!tick && n < 5000);
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(irq_n === 1'b1, "R1 irq_n", int'(irq_n), 1);
    check(tick === 1'b0, "R1 tick", int'(tick), 0);
    check(tout === 1'b0, "R1 tout", int'(tout), 0);
    wait_tick(n);
    check(n == period(7) / 2, "R1 first tick", n, period(7) / 2);
  endtask

  task automatic t_period(input int code);
    int n;
    rate_v = SEL_W'(code);
    send(C_RATE);
    wait_tick(n);
    wait_tick(n);
    check(n == period(code), "R2 tick period", n, period(code));
    step();
    check(tick === 1'b0, "R2 tick width", int'(tick), 0);
  endtask

  task automatic t_clear();
    int n;
    rate_v = 3'd5;
    send(C_RATE);
    send(C_TCLR);
    wait_tick(n);
    check(n == period(5) / 2, "R4 tick after clear", n, period(5) / 2);
  endtask

  task automatic t_wdt();
    int ticks, at, n;
    rate_v = 3'd7;
    send(C_RATE);
    send(C_TCLR | C_WCLR);
    ticks = 0; at = 0;
    for (int j = 1; j <= 40 && at == 0; j++) begin
      step();
      if (tick) ticks++;
      if (tout) at = j;
    end
    check(ticks == 4, "R5 tout on 4th tick", ticks, 4);
    check(at == period(7) / 2 + 3 * period(7), "R5 tout time", at, period(7) / 2 + 3 * period(7));
    // watchdog clear in mid-count restarts the /4 stage
    wait_tick(n);
    wait_tick(n);
    send(C_WCLR);
    ticks = 0; at = 0;
    for (int j = 1; j <= 60 && at == 0; j++) begin
      step();
      if (tick) ticks++;
      if (tout) at = j;
    end
    check(ticks == 4, "R5 tout after wdt clear", ticks, 4);
  endtask

  task automatic t_irq_masked();
    bit low, seen;
    send(C_WON | C_TON);
    send(C_TCLR | C_WCLR);
    low = 0; seen = 0;
    for (int j = 0; j < 60; j++) begin
      step();
      if (tout) seen = 1;
      if (irq_n !== 1'b1) low = 1;
    end
    check(seen, "R6 tout occurred", int'(seen), 1);
    check(!low, "R6 irq masked", int'(low), 0);
    send(C_WOFF | C_TOFF);
  endtask

  task automatic t_flag();
    int n;
    bit high;
    send(C_ION | C_WON);
    send(C_TCLR | C_WCLR);
    n = 0;
    while (!tout && n < 200) begin step(); n++; end
    step();
    check(irq_n === 1'b0, "R7 irq low after tout", int'(irq_n), 0);
    high = 0;
    for (int j = 0; j < 40; j++) begin
      step();
      if (irq_n !== 1'b0) high = 1;
    end
    check(!high, "R7 flag latched", int'(high), 0);
    send(C_WCLR);
    step();
    check(irq_n === 1'b1, "R7 released by wdt clear", int'(irq_n), 1);
    // second time-out, released by interrupt off
    n = 0;
    while (!tout && n < 200) begin step(); n++; end
    step();
    check(irq_n === 1'b0, "R7 irq low again", int'(irq_n), 0);
    send(C_IOFF);
    step();
    check(irq_n === 1'b1, "R7 released by irq off", int'(irq_n), 1);
    send(C_ION);
    step();
    check(irq_n === 1'b1, "R7 flag cleared by irq off", int'(irq_n), 1);
    // third release path: watchdog off
    n = 0;
    while (!tout && n < 200) begin step(); n++; end
    step();
    send(C_WOFF);
    step();
    check(irq_n === 1'b1, "R7 released by wdt off", int'(irq_n), 1);
    send(C_IOFF);
  endtask

  task automatic t_timer_irq();
    int n, lo, hi;
    rate_v = 3'd6;
    send(C_RATE);
    send(C_TON | C_ION);
    send(C_TCLR);
    wait_tick(n);
    step();
    check(irq_n === 1'b0, "R8 irq low after tick", int'(irq_n), 0);
    lo = 1;
    forever begin step(); if (irq_n === 1'b0 && lo < 100) lo++; else break; end
    hi = 1;
    forever begin step(); if (irq_n === 1'b1 && hi < 100) hi++; else break; end
    check(lo == period(6) / 2, "R8 low width", lo, period(6) / 2);
    check(hi == period(6) / 2, "R8 high width", hi, period(6) / 2);
    send(C_TOFF | C_IOFF);
  endtask

  task automatic t_off_wins();
    bit low;
    rate_v = 3'd7;
    send(C_RATE);
    send(C_ION | C_TON | C_TOFF);
    low = 0;
    for (int j = 0; j < 24; j++) begin
      step();
      if (irq_n !== 1'b1) low = 1;
    end
    check(!low, "R6 off strobe wins", int'(low), 0);
    send(C_IOFF);
  endtask

  task automatic t_rate_change(input int from, input int to, input int sw, input int exp);
    int first;
    rate_v = SEL_W'(from);
    send(C_RATE);
    send(C_TCLR);
    first = 0;
    for (int j = 1; j <= 80 && first == 0; j++) begin
      if (j == sw) begin rate_v = SEL_W'(to); cmd = 9'(C_RATE); end
      @(posedge clk); @(negedge clk);
      cmd = '0;
      if (tick && j > sw) first = j;
    end
    check(first == exp, "R9 R3 first tick after rate change", first, exp);
  endtask

  initial begin
    t_reset();
    t_period(7);
    t_period(4);
    t_period(0);
    t_clear();
    t_wdt();
    t_irq_masked();
    t_flag();
    t_timer_irq();
    t_off_wins();
    t_rate_change(0, 7, 21, 28);
    t_rate_change(7, 4, 10, 32);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule